// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller. Its pins are grouped in banks of 32, and each bank has its own registers for direction, output level, pin readback and edge detection. Software changes output levels atomically. Writing ones to a set register or a clear register moves only the selected output latches, so two agents that share a bank never need a read-modify-write sequence.

Each input goes through a two-flop synchronizer. A rising edge or a falling edge, as enabled per pin, records a sticky bit in a status register, and software clears that bit by writing a one to it. A per-pin mask decides which recorded events reach the interrupt outputs. Pins 0 and 1 each have a dedicated interrupt line. Every masked event also drives one shared interrupt line. Register access uses a simple single-cycle bus with a combinational read path. Three banks are interleaved in each 0x100-byte group of the address space.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: Bank b occupies the word addresses ((b / 3) << 8) + ((b % 3) << 2) + OFF, with OFF = 0x00 level, 0x0C direction, 0x18 set, 0x24 clear, 0x30 rising enable, 0x3C falling enable, 0x48 edge status, 0x9C edge mask. Bit k of a bank register belongs to pin 32*b + k. Reads of any other address, or of a bank that is not present, return 0.
- R2: After reset, pin_oe, pin_out, all edge enables, all edge status bits, all masks and all three interrupt outputs are 0.
- R3: Writing the set register raises the output latch for every bit written as 1 and leaves the other latches unchanged. The set and clear addresses both read back the output latches.
- R4: Writing the clear register lowers the output latch for every bit written as 1 and leaves the other latches unchanged.
- R5: A direction bit of 1 makes the pin an output (pin_oe = 1) from the cycle after the write. The output latch keeps any value written while the pin is an input, so a level can be preloaded before the pin is turned to output. pin_oe changes only on a direction write.
- R6: The level register returns the synchronized pin state. A pin change that arrives before clock edge k becomes readable after edge k+1.
- R7: A status bit becomes 1 on a rising edge of its pin when the rising enable is set, and on a falling edge when the falling enable is set. With both enables set, either edge sets the bit. A pin change before clock edge k sets the bit at edge k+2.
- R8: Writing 1s to the status register clears those bits, and bits written as 0 are unchanged. If a new edge and a clear reach the same bit in the same cycle, the bit stays 1.
- R9: irq_any is the OR of (status AND mask) over all pins. A status bit whose mask bit is 0 does not drive any interrupt output.
- R10: irq_pin0 equals status AND mask for pin 0, and irq_pin1 equals status AND mask for pin 1. Both also drive irq_any.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32*NUM_BANKS | Pad input levels |
| pin_out | output | 32*NUM_BANKS | Output latches |
| pin_oe | output | 32*NUM_BANKS | Output enables, 1 = drive |
| irq_pin0 | output | 1 | Dedicated interrupt for pin 0 |
| irq_pin1 | output | 1 | Dedicated interrupt for pin 1 |
| irq_any | output | 1 | Shared interrupt from all masked events |

## Verification
A bad address decode shows up at once as a wrong bus_rdata value, or as a pin outside the written bank that moves one cycle after a write. A wrong synchronizer or edge state makes a status bit, or an interrupt, appear one cycle early, one cycle late or not at all. The bench catches this by reading the status at the exact cycle R7 gives and by placing a clear in the same cycle as a new edge. Because the interrupt outputs are combinational from status and mask, a wrong mask or status bit shows at the interrupt pins in the same cycle.

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl #(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic [32*NUM_BANKS-1:0]   pin_in,
  output logic [32*NUM_BANKS-1:0]   pin_out,
  output logic [32*NUM_BANKS-1:0]   pin_oe,
  output logic                      irq_pin0,
  output logic                      irq_pin1,
  output logic                      irq_any
);
  localparam int NPINS   = 32 * NUM_BANKS;
  localparam int OFF_LVL = 'h00;
  localparam int OFF_DIR = 'h0C;
  localparam int OFF_SET = 'h18;
  localparam int OFF_CLR = 'h24;
  localparam int OFF_REN = 'h30;
  localparam int OFF_FEN = 'h3C;
  localparam int OFF_STS = 'h48;
  localparam int OFF_MSK = 'h9C;

  function automatic logic [ADDR_W-1:0] reg_at(input int bank, input int off);
    return ADDR_W'(((bank / 3) << 8) + ((bank % 3) << 2) + off);
  endfunction

  logic [NPINS-1:0] dir_q, out_q, ren_q, fen_q, sts_q, msk_q;
  logic [NPINS-1:0] sync1, sync2, prev;
  logic [NPINS-1:0] sts_clr, edge_hit, pend;
  logic [NUM_BANKS-1:0] wr_dir, wr_set, wr_clr, wr_ren, wr_fen, wr_msk;

  always_comb begin
    bus_rdata = '0;
    sts_clr   = '0;
    wr_dir = '0; wr_set = '0; wr_clr = '0;
    wr_ren = '0; wr_fen = '0; wr_msk = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bus_addr == reg_at(b, OFF_LVL)) bus_rdata = sync2[b*32 +: 32];
      if (bus_addr == reg_at(b, OFF_DIR)) bus_rdata = dir_q[b*32 +: 32];
      if (bus_addr == reg_at(b, OFF_SET)) bus_rdata = out_q[b*32 +: 32];
      if (bus_addr == reg_at(b, OFF_CLR)) bus_rdata = out_q[b*32 +: 32];
      if (bus_addr == reg_at(b, OFF_REN)) bus_rdata = ren_q[b*32 +: 32];
      if (bus_addr == reg_at(b, OFF_FEN)) bus_rdata = fen_q[b*32 +: 32];
      if (bus_addr == reg_at(b, OFF_STS)) bus_rdata = sts_q[b*32 +: 32];
      if (bus_addr == reg_at(b, OFF_MSK)) bus_rdata = msk_q[b*32 +: 32];
      if (bus_we) begin
        wr_dir[b] = (bus_addr == reg_at(b, OFF_DIR));
        wr_set[b] = (bus_addr == reg_at(b, OFF_SET));
        wr_clr[b] = (bus_addr == reg_at(b, OFF_CLR));
        wr_ren[b] = (bus_addr == reg_at(b, OFF_REN));
        wr_fen[b] = (bus_addr == reg_at(b, OFF_FEN));
        wr_msk[b] = (bus_addr == reg_at(b, OFF_MSK));
        if (bus_addr == reg_at(b, OFF_STS)) sts_clr[b*32 +: 32] = bus_wdata;
      end
    end
  end

  assign edge_hit = (sync2 & ~prev & ren_q) | (~sync2 & prev & fen_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      prev  <= '0;
      sts_q <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
      prev  <= sync2;
      sts_q <= (sts_q & ~sts_clr) | edge_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      ren_q <= '0;
      fen_q <= '0;
      msk_q <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (wr_dir[b]) dir_q[b*32 +: 32] <= bus_wdata;
        if (wr_set[b]) out_q[b*32 +: 32] <= out_q[b*32 +: 32] | bus_wdata;
        if (wr_clr[b]) out_q[b*32 +: 32] <= out_q[b*32 +: 32] & ~bus_wdata;
        if (wr_ren[b]) ren_q[b*32 +: 32] <= bus_wdata;
        if (wr_fen[b]) fen_q[b*32 +: 32] <= bus_wdata;
        if (wr_msk[b]) msk_q[b*32 +: 32] <= bus_wdata;
      end
    end
  end

  assign pend     = sts_q & msk_q;
  assign pin_out  = out_q;
  assign pin_oe   = dir_q;
  assign irq_pin0 = pend[0];
  assign irq_pin1 = pend[1];
  assign irq_any  = |pend;
endmodule

module gpio_bank_ctrl_chk #(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 12
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic                    bus_we,
  input logic [31:0]             bus_wdata,
  input logic [32*NUM_BANKS-1:0] pin_out,
  input logic [32*NUM_BANKS-1:0] pin_oe,
  input logic                    irq_pin0,
  input logic                    irq_pin1,
  input logic                    irq_any
);
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'('h0C)) |=> (pin_oe[31:0] == $past(bus_wdata))); // R5
  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> $stable(pin_oe)); // R5
  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'('h18)) |=> ((pin_out[31:0] & $past(bus_wdata)) == $past(bus_wdata))); // R3
  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'('h24)) |=> ((pin_out[31:0] & $past(bus_wdata)) == 32'h0)); // R4
  AST_PIN0_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin0 |-> irq_any); // R10
  AST_PIN1_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin1 |-> irq_any); // R9
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq_pin0(irq_pin0), .irq_pin1(irq_pin1), .irq_any(irq_any)
);

// File: tb/gpio_bank_ctrl_test.sv
module gpio_bank_ctrl_test;
  localparam int NB = 3;
  localparam int NP = 32 * NB;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] ext_in = '0, pin_in, pin_out, pin_oe;
  logic irq_pin0, irq_pin1, irq_any;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;
  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext_in);

  gpio_bank_ctrl #(.NUM_BANKS(NB), .ADDR_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_pin0(irq_pin0),
    .irq_pin1(irq_pin1), .irq_any(irq_any));

  // {we, addr, wdata, expected read}
  localparam int NV = 17;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 12'h00C, 32'h0000FFFF, 32'h0},        // R5 dir b0
    {1'b0, 12'h00C, 32'h0,        32'h0000FFFF}, // R5
    {1'b1, 12'h018, 32'h000000A5, 32'h0},        // R3
    {1'b0, 12'h018, 32'h0,        32'h000000A5}, // R3
    {1'b1, 12'h024, 32'h00000021, 32'h0},        // R4
    {1'b0, 12'h018, 32'h0,        32'h00000084}, // R4
    {1'b1, 12'h01C, 32'h80000001, 32'h0},        // R1 set b1
    {1'b0, 12'h028, 32'h0,        32'h80000001}, // R1 clear b1 reads latch
    {1'b1, 12'h038, 32'h12345678, 32'h0},        // R1 rise b2
    {1'b0, 12'h038, 32'h0,        32'h12345678}, // R1
    {1'b1, 12'h040, 32'hCAFE0000, 32'h0},        // R1 fall b1
    {1'b0, 12'h040, 32'h0,        32'hCAFE0000}, // R1
    {1'b0, 12'h03C, 32'h0,        32'h0},        // R1 fall b0 untouched
    {1'b1, 12'h0A4, 32'hFFFF0000, 32'h0},        // R1 mask b2
    {1'b0, 12'h0A4, 32'h0,        32'hFFFF0000}, // R1
    {1'b0, 12'h104, 32'h0,        32'h0},        // R1 absent bank
    {1'b0, 12'h054, 32'h0,        32'h0}         // R1 unmapped
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    #1;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 pin_oe", pin_oe[31:0] | pin_oe[63:32] | pin_oe[95:64], 32'h0);
    chk("R2 pin_out", pin_out[31:0] | pin_out[63:32] | pin_out[95:64], 32'h0);
    chk("R2 irq", {29'h0, irq_pin0, irq_pin1, irq_any}, 32'h0);
    rst_n = 1;
    rd(12'h048, r); chk("R2 status b0", r, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][75:64], r);
        chk($sformatf("R1/R3/R4/R5 vector %0d", i), r, VEC[i][31:0]);
      end
    end

    chk("R1 bank0 pins", pin_out[31:0], 32'h00000084);
    chk("R1 bank1 pins", pin_out[63:32], 32'h80000001);
    settle();
    rd(12'h000, r); chk("R6 level of outputs", r, 32'h00000084);

    // R5 preload while input
    wr(12'h018, 32'h00100000);
    chk("R5 preload latch", pin_out[31:0], 32'h00100084);
    chk("R5 still input", {31'h0, pin_oe[20]}, 32'h0);
    wr(12'h00C, 32'h001FFFFF);
    chk("R5 turned output", pin_oe[31:0], 32'h001FFFFF);

    wr(12'h038, 32'h0); wr(12'h0A4, 32'h0); wr(12'h040, 32'h0);

    // R6 level latency on bank 2
    @(negedge clk); ext_in[95:64] = 32'h5A5A0000;
    rd(12'h008, r); chk("R6 level one edge", r, 32'h0);
    rd(12'h008, r); chk("R6 level two edges", r, 32'h5A5A0000);
    settle();
    rd(12'h050, r); chk("R7 no enable no event", r, 32'h0);

    // R7 rising only, R9 mask gating, R8 clear
    wr(12'h034, 32'h8); wr(12'h0A0, 32'h0);
    @(negedge clk); ext_in[35] = 1; settle();
    rd(12'h04C, r); chk("R7 rising sets", r, 32'h8);
    chk("R9 masked off", {31'h0, irq_any}, 32'h0);
    wr(12'h0A0, 32'h8); #1;
    chk("R9 mask on", {31'h0, irq_any}, 32'h1);
    wr(12'h04C, 32'h0);
    rd(12'h04C, r); chk("R8 zero write kept", r, 32'h8);
    wr(12'h04C, 32'h8);
    rd(12'h04C, r); chk("R8 one write clears", r, 32'h0);
    chk("R9 irq drops", {31'h0, irq_any}, 32'h0);
    @(negedge clk); ext_in[35] = 0; settle();
    rd(12'h04C, r); chk("R7 falling ignored", r, 32'h0);

    // R7 both enables on pin 36
    wr(12'h034, 32'h18); wr(12'h040, 32'h10);
    @(negedge clk); ext_in[36] = 1; settle();
    rd(12'h04C, r); chk("R7 both rise", r, 32'h10);
    wr(12'h04C, 32'h10);
    @(negedge clk); ext_in[36] = 0; settle();
    rd(12'h04C, r); chk("R7 both fall", r, 32'h10);

    // R8 new edge wins over same-cycle clear
    @(negedge clk); ext_in[36] = 1;
    @(negedge clk);
    @(negedge clk); bus_we = 1; bus_addr = 12'h04C; bus_wdata = 32'h10;
    @(negedge clk); bus_we = 0;
    rd(12'h04C, r); chk("R8 edge wins", r, 32'h10);
    wr(12'h04C, 32'hFFFFFFFF);
    rd(12'h04C, r); chk("R8 clear all", r, 32'h0);

    // R10 dedicated lines
    wr(12'h0A0, 32'h0);
    wr(12'h00C, 32'h0); wr(12'h030, 32'h3); wr(12'h09C, 32'h1);
    @(negedge clk); ext_in[0] = 1; settle();
    chk("R10 pin0 lines", {29'h0, irq_pin0, irq_pin1, irq_any}, 32'h5);
    @(negedge clk); ext_in[1] = 1; settle();
    chk("R10 pin1 masked", {31'h0, irq_pin1}, 32'h0);
    wr(12'h09C, 32'h3); #1;
    chk("R10 pin1 line", {29'h0, irq_pin0, irq_pin1, irq_any}, 32'h7);
    wr(12'h048, 32'h1); #1;
    chk("R10 pin0 cleared", {29'h0, irq_pin0, irq_pin1, irq_any}, 32'h3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule